// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer

This block holds two 8-bit up-counting timers, a lower one and an upper one. Each timer has its own count register, match value, run bit, tick-source select, PWM-mode bit, pulse output and interrupt request. A set of prescaled tick strobes comes in from outside. Each timer advances only on clock cycles where its selected strobe is high.

A fuse bit in the lower timer's control word joins the pair into one 16-bit timer. While it is set, the two counts form one 16-bit count and the two match values form one 16-bit match value. The lower timer supplies the low byte, and its run bit and tick select drive the joined timer. The upper timer drives the pulse and the interrupt. The lower timer's outputs stay quiet, and both PWM bits are ignored.

Software uses a small word-wide register port with per-byte write enables. Writing both bytes at once loads the 16-bit match value in one cycle. A read of the count captures both bytes on the same clock edge.

Top module: `casc_timer_pair`

## Requirements
- R1: With the fuse bit clear and PWM off, a running timer counts up by one on each cycle where its selected tick is high. On a tick that finds the count equal to its match value, the count returns to 0, the pulse output toggles and the interrupt is high for exactly the next cycle. A count above the match value wraps from 255 to 0 with no interrupt.
- R2: With the fuse bit (control bit 4 at address 0) set, the count is {upper, lower} and the match value is {upper match, lower match}. The lower timer's run bit alone starts and stops it, and the upper run bit has no effect.
- R3: With the fuse bit set, only the lower timer's tick select (control bits 2:1, index into tick_i) paces the 16-bit count. The upper select has no effect.
- R4: With the fuse bit set, pulse_o[0] is low and irq_o[0] stays low. pulse_o[1] toggles and irq_o[1] pulses on each 16-bit match.
- R5: With the fuse bit set, both PWM bits (control bit 3) are ignored, and the joined timer behaves as in R1 at 16 bits.
- R6: A timer whose run bit (control bit 0) is 0 holds its count. Writing 1 to the self-clearing clear bit (control bit 5) zeroes that count, and in fused mode the lower clear zeroes both bytes. It also sets the pulse low and cancels any match on that edge.
- R7: A write to address 2 with both byte enables loads the low byte into the lower match and the high byte into the upper match on one edge. A match value written while stopped governs the first period after restart.
- R8: A read of address 3 returns {upper count, lower count}, both sampled on the same edge, on rd_data_o one cycle after rd_en_i. Addresses 0, 1 and 2 read back the control words (clear reads 0, fuse bit only at address 0) and the match pair.
- R9: With the fuse bit clear and PWM on, the timer counts freely from 0 to 255. Its pulse is high while the count is below its match value, and its interrupt pulses once on each wrap to 0.
- R10: After reset, all counts, match values, control bits, pulses, interrupts and read data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 4 | Prescaled tick strobes, selected per timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 lower control, 1 upper control, 2 match pair |
| wr_data_i | input | 16 | Write data |
| wr_be_i | input | 2 | Byte enables; control writes use bit 0 |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Read address: 0, 1 control, 2 match pair, 3 count pair |
| rd_data_o | output | 16 | Read data, valid the cycle after rd_en_i and held |
| pulse_o | output | 2 | Pulse outputs, [0] lower, [1] upper |
| irq_o | output | 2 | One-cycle interrupt requests, [0] lower, [1] upper |

## Verification
The hardest case to reach from the ports is a read landing on the exact cycle when the low byte of the fused count carries into the high byte. A torn read there differs from the true value by 256. To reach it, the bench sets a 16-bit match value above 0x00FF, runs the fused timer on the every-cycle tick and issues a read on every cycle across the carry. A behavioural model checks each returned word. The bench also rewrites the match value while the timer is stopped and measures the cycles to the first interrupt after restart.

// File: rtl/casc_timer_pkg.sv
package casc_timer_pkg;

  typedef enum logic [1:0] {
    REG_CTRL_LO = 2'd0,
    REG_CTRL_HI = 2'd1,
    REG_MATCH   = 2'd2,
    REG_COUNT   = 2'd3
  } reg_sel_e;

  localparam int RUN_BIT = 0;
  localparam int SEL_LSB = 1;

endpackage

// File: rtl/casc_timer_regs.sv
module casc_timer_regs
  import casc_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [1:0]                wr_addr_i,
  input  logic [2*CNT_W-1:0]        wr_data_i,
  input  logic [1:0]                wr_be_i,
  input  logic                      rd_en_i,
  input  logic [1:0]                rd_addr_i,
  input  logic [1:0][CNT_W-1:0]     cnt_i,
  output logic [2*CNT_W-1:0]        rd_data_o,
  output logic [1:0]                run_o,
  output logic [1:0][SEL_W-1:0]     sel_o,
  output logic [1:0]                pwm_o,
  output logic                      casc_o,
  output logic [1:0]                clr_o,
  output logic [1:0][CNT_W-1:0]     match_o
);

  localparam int DW     = 2 * CNT_W;
  localparam int PWM_B  = SEL_LSB + SEL_W;
  localparam int CASC_B = PWM_B + 1;
  localparam int CLR_B  = CASC_B + 1;

  logic [1:0]              run_q, run_d;
  logic [1:0][SEL_W-1:0]   sel_q, sel_d;
  logic [1:0]              pwm_q, pwm_d;
  logic                    casc_q, casc_d;
  logic [1:0][CNT_W-1:0]   match_q, match_d;
  logic [DW-1:0]           rd_q, rd_d;
  logic [1:0][DW-1:0]      ctrl_word;

  // control words as seen on the read path
  always_comb begin
    for (int k = 0; k < 2; k++) begin
      ctrl_word[k]                     = '0;
      ctrl_word[k][RUN_BIT]            = run_q[k];
      ctrl_word[k][SEL_LSB +: SEL_W]   = sel_q[k];
      ctrl_word[k][PWM_B]              = pwm_q[k];
    end
    ctrl_word[0][CASC_B] = casc_q;
  end

  // next state of the register file
  always_comb begin
    run_d   = run_q;
    sel_d   = sel_q;
    pwm_d   = pwm_q;
    casc_d  = casc_q;
    match_d = match_q;
    clr_o   = '0;
    if (wr_en_i) begin
      for (int k = 0; k < 2; k++) begin
        if (wr_addr_i == 2'(k) && wr_be_i[0]) begin
          run_d[k] = wr_data_i[RUN_BIT];
          sel_d[k] = wr_data_i[SEL_LSB +: SEL_W];
          pwm_d[k] = wr_data_i[PWM_B];
          clr_o[k] = wr_data_i[CLR_B];
        end
        if (wr_addr_i == REG_MATCH && wr_be_i[k]) begin
          match_d[k] = wr_data_i[k*CNT_W +: CNT_W];
        end
      end
      if (wr_addr_i == REG_CTRL_LO && wr_be_i[0]) begin
        casc_d = wr_data_i[CASC_B];
      end
    end
  end

  // read capture: both count bytes enter on the same edge
  always_comb begin
    rd_d = rd_q;
    if (rd_en_i) begin
      unique case (rd_addr_i)
        REG_CTRL_LO: rd_d = ctrl_word[0];
        REG_CTRL_HI: rd_d = ctrl_word[1];
        REG_MATCH:   rd_d = {match_q[1], match_q[0]};
        default:     rd_d = {cnt_i[1], cnt_i[0]};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      sel_q   <= '0;
      pwm_q   <= '0;
      casc_q  <= 1'b0;
      match_q <= '0;
      rd_q    <= '0;
    end else begin
      run_q   <= run_d;
      sel_q   <= sel_d;
      pwm_q   <= pwm_d;
      casc_q  <= casc_d;
      match_q <= match_d;
      rd_q    <= rd_d;
    end
  end

  assign rd_data_o = rd_q;
  assign run_o     = run_q;
  assign sel_o     = sel_q;
  assign pwm_o     = pwm_q;
  assign casc_o    = casc_q;
  assign match_o   = match_q;

endmodule

// File: rtl/casc_timer_seq.sv
module casc_timer_seq #(
  parameter int CNT_W  = 8,
  parameter int N_TICK = 4,
  parameter int SEL_W  = 2
) (
  input  logic [N_TICK-1:0]         tick_i,
  input  logic [1:0]                run_i,
  input  logic [1:0][SEL_W-1:0]     sel_i,
  input  logic [1:0]                pwm_i,
  input  logic                      casc_i,
  input  logic [1:0]                clr_i,
  input  logic [1:0][CNT_W-1:0]     cnt_i,
  input  logic [1:0][CNT_W-1:0]     match_i,
  output logic [1:0]                inc_o,
  output logic [1:0]                zero_o,
  output logic [1:0]                evt_o,
  output logic [1:0]                tog_clr_o,
  output logic [1:0]                pwm_eff_o,
  output logic [1:0]                force_off_o
);

  localparam logic [CNT_W-1:0] TOP_V = {CNT_W{1'b1}};

  logic [1:0] step;
  logic [1:0] at_match;
  logic [1:0] at_top;
  logic       wide_hit;

  for (genvar k = 0; k < 2; k++) begin : g_step
    assign step[k]     = run_i[k] & tick_i[sel_i[k]];
    assign at_match[k] = (cnt_i[k] == match_i[k]);
    assign at_top[k]   = (cnt_i[k] == TOP_V);
  end

  assign wide_hit = step[0] & at_match[0] & at_match[1];

  always_comb begin
    inc_o       = '0;
    zero_o      = '0;
    evt_o       = '0;
    tog_clr_o   = '0;
    pwm_eff_o   = '0;
    force_off_o = '0;
    if (casc_i) begin
      // joined 16-bit timer: lower control, upper outputs
      inc_o[0]    = step[0];
      inc_o[1]    = step[0] & at_top[0];
      zero_o      = {2{clr_i[0] | wide_hit}};
      evt_o[1]    = wide_hit & ~clr_i[0];
      tog_clr_o   = {2{clr_i[0]}};
      force_off_o = 2'b01;
    end else begin
      for (int k = 0; k < 2; k++) begin
        inc_o[k]     = step[k];
        tog_clr_o[k] = clr_i[k];
        pwm_eff_o[k] = pwm_i[k];
        if (pwm_i[k]) begin
          zero_o[k] = clr_i[k];
          evt_o[k]  = step[k] & at_top[k] & ~clr_i[k];
        end else begin
          zero_o[k] = clr_i[k] | (step[k] & at_match[k]);
          evt_o[k]  = step[k] & at_match[k] & ~clr_i[k];
        end
      end
    end
  end

endmodule

// File: rtl/casc_timer_cnt.sv
module casc_timer_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             zero_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (zero_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/casc_timer_out.sv
module casc_timer_out #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             tog_clr_i,
  input  logic             pwm_eff_i,
  input  logic             force_off_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] match_i,
  output logic             pulse_o,
  output logic             irq_o
);

  logic tog_q, tog_d;
  logic irq_q, irq_d;

  always_comb begin
    tog_d = tog_q;
    if (tog_clr_i) begin
      tog_d = 1'b0;
    end else if (evt_i && !pwm_eff_i) begin
      tog_d = ~tog_q;
    end
    irq_d = evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    if (force_off_i) begin
      pulse_o = 1'b0;
    end else if (pwm_eff_i) begin
      pulse_o = (cnt_i < match_i);
    end else begin
      pulse_o = tog_q;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/casc_timer_pair.sv
module casc_timer_pair
  import casc_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int N_TICK = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_TICK-1:0]    tick_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [2*CNT_W-1:0]   wr_data_i,
  input  logic [1:0]           wr_be_i,
  input  logic                 rd_en_i,
  input  logic [1:0]           rd_addr_i,
  output logic [2*CNT_W-1:0]   rd_data_o,
  output logic [1:0]           pulse_o,
  output logic [1:0]           irq_o
);

  localparam int SEL_W = (N_TICK > 1) ? $clog2(N_TICK) : 1;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [1:0]              run, pwm, clr;
  logic [1:0][SEL_W-1:0]   sel;
  logic                    casc;
  logic [1:0][CNT_W-1:0]   match, cnt;
  logic [1:0]              inc, zero, evt, tog_clr, pwm_eff, force_off;

  casc_timer_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wr_be_i   (wr_be_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .cnt_i     (cnt),
    .rd_data_o (rd_data_o),
    .run_o     (run),
    .sel_o     (sel),
    .pwm_o     (pwm),
    .casc_o    (casc),
    .clr_o     (clr),
    .match_o   (match)
  );

  casc_timer_seq #(.CNT_W(CNT_W), .N_TICK(N_TICK), .SEL_W(SEL_W)) u_seq (
    .tick_i      (tick_i),
    .run_i       (run),
    .sel_i       (sel),
    .pwm_i       (pwm),
    .casc_i      (casc),
    .clr_i       (clr),
    .cnt_i       (cnt),
    .match_i     (match),
    .inc_o       (inc),
    .zero_o      (zero),
    .evt_o       (evt),
    .tog_clr_o   (tog_clr),
    .pwm_eff_o   (pwm_eff),
    .force_off_o (force_off)
  );

  for (genvar k = 0; k < 2; k++) begin : g_slice
    casc_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .inc_i  (inc[k]),
      .zero_i (zero[k]),
      .cnt_o  (cnt[k])
    );

    casc_timer_out #(.CNT_W(CNT_W)) u_out (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .evt_i       (evt[k]),
      .tog_clr_i   (tog_clr[k]),
      .pwm_eff_i   (pwm_eff[k]),
      .force_off_i (force_off[k]),
      .cnt_i       (cnt[k]),
      .match_i     (match[k]),
      .pulse_o     (pulse_o[k]),
      .irq_o       (irq_o[k])
    );
  end

endmodule

// File: rtl/casc_timer_chk.sv
module casc_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             casc,
  input logic [1:0]       run,
  input logic [1:0]       clr,
  input logic [1:0]       pwm,
  input logic [CNT_W-1:0] cnt_lo,
  input logic [CNT_W-1:0] cnt_hi,
  input logic [1:0]       pulse,
  input logic [1:0]       irq
);

  AST_IRQ_LO_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] |-> (cnt_lo == '0)); // R1

  AST_IRQ_HI_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> (cnt_hi == '0)); // R1

  AST_FUSED_IRQ_FULL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && $past(casc) && irq[1]) |-> (cnt_lo == '0)); // R2

  AST_UPPER_RUN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !run[0] && !clr[0]) |=> $stable(cnt_hi)); // R2

  AST_LO_SILENT_FUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && $past(casc)) |-> !irq[0]); // R4

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !clr[0]) |=> $stable(cnt_lo)); // R6

  AST_CLEAR_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr[0] |=> (!pulse[0] || (pwm[0] && !casc))); // R6

endmodule

bind casc_timer_pair casc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .casc   (casc),
  .run    (run),
  .clr    (clr),
  .pwm    (pwm),
  .cnt_lo (cnt[0]),
  .cnt_hi (cnt[1]),
  .pulse  (pulse_o),
  .irq    (irq_o)
);

// File: tb/casc_timer_pair_tb_top.sv
`timescale 1ns/1ps
module casc_timer_pair_tb_top;

  logic        clk;
  logic        rst_n;
  logic [3:0]  tick;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  wr_be;
  logic        rd_en;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic [1:0]  pulse;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit chk_on = 0;
  bit done = 0;
  string cur_req = "R10";

  casc_timer_pair dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_be_i(wr_be),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pulse_o(pulse), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // tick strobes: every cycle, every 2nd, every 3rd, every 5th
  always @(negedge clk) begin
    cyc = cyc + 1;
    tick = {(cyc % 5 == 0), (cyc % 3 == 0), (cyc % 2 == 0), 1'b1};
  end

  // ---------------- behavioural reference model ----------------
  int m_cnt[2], m_cmp[2], m_run[2], m_sel[2], m_pwm[2], m_tog[2], m_irq[2];
  int m_casc, m_rd, m_rc;

  function automatic int ctrl_word(int k);
    return m_run[k] + m_sel[k] * 2 + m_pwm[k] * 8 + ((k == 0) ? m_casc * 16 : 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || m_rc < 2) begin
      if (!rst_n) m_rc = 0; else m_rc = m_rc + 1;
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_cmp[k] = 0; m_run[k] = 0; m_sel[k] = 0;
        m_pwm[k] = 0; m_tog[k] = 0; m_irq[k] = 0;
      end
      m_casc = 0; m_rd = 0;
    end else begin
      int clr[2];
      int st[2];
      int c16, k16;
      if (rd_en) begin
        case (rd_addr)
          2'd0: m_rd = ctrl_word(0);
          2'd1: m_rd = ctrl_word(1);
          2'd2: m_rd = m_cmp[1] * 256 + m_cmp[0];
          default: m_rd = m_cnt[1] * 256 + m_cnt[0];
        endcase
      end
      for (int k = 0; k < 2; k++) begin
        clr[k] = (wr_en && wr_addr == 2'(k) && wr_be[0] && wr_data[5]) ? 1 : 0;
        st[k]  = (m_run[k] != 0 && tick[m_sel[k]]) ? 1 : 0;
        m_irq[k] = 0;
      end
      if (m_casc != 0) begin
        if (clr[0] != 0) begin
          m_cnt[0] = 0; m_cnt[1] = 0; m_tog[0] = 0; m_tog[1] = 0;
        end else if (st[0] != 0) begin
          c16 = m_cnt[1] * 256 + m_cnt[0];
          k16 = m_cmp[1] * 256 + m_cmp[0];
          if (c16 == k16) begin
            c16 = 0; m_tog[1] = 1 - m_tog[1]; m_irq[1] = 1;
          end else begin
            c16 = (c16 + 1) % 65536;
          end
          m_cnt[1] = c16 / 256; m_cnt[0] = c16 % 256;
        end
      end else begin
        for (int k = 0; k < 2; k++) begin
          if (clr[k] != 0) begin
            m_cnt[k] = 0; m_tog[k] = 0;
          end else if (st[k] != 0) begin
            if (m_pwm[k] != 0) begin
              m_irq[k] = (m_cnt[k] == 255) ? 1 : 0;
              m_cnt[k] = (m_cnt[k] + 1) % 256;
            end else if (m_cnt[k] == m_cmp[k]) begin
              m_cnt[k] = 0; m_tog[k] = 1 - m_tog[k]; m_irq[k] = 1;
            end else begin
              m_cnt[k] = (m_cnt[k] + 1) % 256;
            end
          end
        end
      end
      if (wr_en) begin
        if (wr_addr <= 2'd1 && wr_be[0]) begin
          m_run[wr_addr] = int'(wr_data[0]);
          m_sel[wr_addr] = int'(wr_data[2:1]);
          m_pwm[wr_addr] = int'(wr_data[3]);
          if (wr_addr == 2'd0) m_casc = int'(wr_data[4]);
        end
        if (wr_addr == 2'd2) begin
          if (wr_be[0]) m_cmp[0] = int'(wr_data[7:0]);
          if (wr_be[1]) m_cmp[1] = int'(wr_data[15:8]);
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      int ep0, ep1;
      ep0 = (m_casc != 0) ? 0 : (m_pwm[0] != 0) ? int'(m_cnt[0] < m_cmp[0]) : m_tog[0];
      ep1 = (m_casc != 0) ? m_tog[1] : (m_pwm[1] != 0) ? int'(m_cnt[1] < m_cmp[1]) : m_tog[1];
      check(cur_req, "pulse0", int'(pulse[0]), ep0);
      check(cur_req, "pulse1", int'(pulse[1]), ep1);
      check(cur_req, "irq0", int'(irq[0]), m_irq[0]);
      check(cur_req, "irq1", int'(irq[1]), m_irq[1]);
      check(cur_req, "rd_data", int'(rd_data), m_rd);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int val);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    val = int'(rd_data);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int v, a, b, n, hits0, hi_cnt;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
    rd_en = 1'b0; rd_addr = '0; tick = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1;

    // R10: reset state
    cur_req = "R10";
    rd(2'd0, v); check("R10", "ctrl0", v, 0);
    rd(2'd2, v); check("R10", "match", v, 0);
    rd(2'd3, v); check("R10", "count", v, 0);
    check("R10", "pulse", int'(pulse), 0);

    // R1: independent timers on different ticks
    cur_req = "R1";
    wr(2'd2, 16'h0503, 2'b11);
    wr(2'd1, 16'h0003, 2'b01);
    wr(2'd0, 16'h0001, 2'b01);
    repeat (80) @(negedge clk);

    // R9: lower in PWM, match 0x40, every-cycle tick
    cur_req = "R9";
    wr(2'd2, 16'h0040, 2'b01);
    wr(2'd0, 16'h0009, 2'b01);
    repeat (600) @(negedge clk);
    hi_cnt = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (pulse[0]) hi_cnt++;
    end
    check("R9", "pwm high cycles per period", hi_cnt, 64);

    // R6: stop holds, clear zeroes
    cur_req = "R6";
    wr(2'd0, 16'h0000, 2'b01);
    rd(2'd3, a);
    repeat (20) @(negedge clk);
    rd(2'd3, b);
    check("R6", "held lower count", b & 16'hff, a & 16'hff);
    wr(2'd0, 16'h0020, 2'b01);
    rd(2'd3, v);
    check("R6", "cleared lower count", v & 16'hff, 0);
    check("R6", "pulse0 after clear", int'(pulse[0]), 0);

    // R2 R3 R5 R4: fused, upper set to run on another tick with PWM
    cur_req = "R5";
    wr(2'd1, 16'h000F, 2'b01);
    wr(2'd0, 16'h0030, 2'b01);
    wr(2'd2, 16'h0102, 2'b11);
    wr(2'd0, 16'h0019, 2'b01);
    hits0 = 0;
    for (int i = 0; i < 40; i++) begin
      rd(2'd3, v);
      for (int j = 0; j < 17; j++) begin
        @(negedge clk);
        if (pulse[0] || irq[0]) hits0++;
      end
    end
    check("R4", "lower activity while fused", hits0, 0);
    rd(2'd0, v);
    check("R3", "ctrl0 readback", v, 16'h0019);

    // R2: lower stopped, upper running: no count
    cur_req = "R2";
    wr(2'd0, 16'h0010, 2'b01);
    wr(2'd1, 16'h0001, 2'b01);
    rd(2'd3, a);
    repeat (30) @(negedge clk);
    rd(2'd3, b);
    check("R2", "fused count with upper run only", b, a);

    // R7: match rewritten while stopped governs the next period
    cur_req = "R7";
    wr(2'd2, 16'h0010, 2'b11);
    wr(2'd0, 16'h0030, 2'b01);
    wr(2'd0, 16'h0011, 2'b01);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq[1] && n < 100);
    check("R7", "cycles to first fused irq", n, 17);

    // R8: read on every cycle across the low-byte carry
    cur_req = "R8";
    wr(2'd0, 16'h0010, 2'b01);
    wr(2'd2, 16'h0300, 2'b11);
    wr(2'd0, 16'h0030, 2'b01);
    wr(2'd0, 16'h0011, 2'b01);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'd3;
    repeat (600) @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    check("R8", "last count read", int'(rd_data), m_rd);

    // R1: back to independent mode
    cur_req = "R1";
    wr(2'd0, 16'h0005, 2'b01);
    repeat (100) @(negedge clk);

    finish_run();
  end

endmodule